// File: doc/BRIEF.md
# Descriptor-Chained Peripheral-to-Memory Transfer Channel

This block is a single transfer channel that moves 32-bit words from a source (normally a fixed peripheral FIFO address) to word-aligned memory. Its setup is not written register by register. Software places a chain of descriptors in memory, loads the address of the first one and sets the enable bit. The channel then reads each descriptor itself, moves the data it describes, and follows the link to the next descriptor until it finds a null link.

Each descriptor is five consecutive words: source address, destination address, count/chunk word, mode word and link pointer. In paced mode a peripheral request line starts each chunk of beats, and a one-cycle acknowledge closes the chunk. In unpaced mode the channel copies memory to memory with no request. The mode word has two active-low per-side reload controls. When a side's control is set, that side's address carries on from where the previous block ended, so several blocks can be gathered into one contiguous buffer. A sticky completion flag reports the end of the chain and clears when it is read.

Top module: `lldma_channel`

## Requirements
- R1: Register map, selected by reg_addr[3:2]: 0x0 run bit (bit 0), 0x4 descriptor pointer, 0x8 mode word, 0xC status. Writing 1 to the run bit while idle starts the channel. The run bit reads 1 while the chain is active and returns to 0 by itself when the chain ends or stops on an error. After reset every register reads 0 and no memory request is issued.
- R2: On start, and at each link, the channel issues five word reads at P, P+4, P+8, P+12 and P+16 (P is the descriptor address). These words are, in order, source, destination, count/chunk word, mode word and link. No data read or write is issued before the fifth fetch read completes.
- R3: Count/chunk word: bits [15:0] give the number of 32-bit beats per block. For a byte length L this is ceil(L/4), so a partial last word moves as a full word. Each beat is one read from the source address followed by one write of that data to the destination address. A count of 0 moves nothing.
- R4: Mode word bit 0 (source) and bit 1 (destination) each select increment (1: the address grows by 4 after every beat) or fixed (0). The two bits act independently.
- R5: Mode word bit 2 set selects paced mode. Before each chunk the channel waits for per_req. A chunk is 2^c beats, where c is the count/chunk word bits [17:16], and it is cut short at the block end. per_ack pulses for one cycle with the chunk's last write. With bit 2 clear the block runs without per_req and per_ack stays low.
- R6: Mode word bit 4 (source) and bit 5 (destination) are active-low reload controls. 0 loads that side's address from the descriptor being fetched. 1 ignores the fetched word and keeps the running address. The decision uses the mode word in force before the fetch: for the first descriptor this is the value software wrote at 0x8. The fetched mode word then replaces it, and 0x8 reads it back.
- R7: A link word of 0 ends the chain after that block. Any other value is fetched as the next descriptor.
- R8: Status bit 0 sets once when the last block of the chain completes. A status read returns the flag and clears it. If the flag sets in the same cycle as a status read, the set wins, so the completion is reported by a later read.
- R9: If the destination address in force after a fetch is not word aligned (bits [1:0] not 00), status bit 1 sets, the channel stops and the run bit clears, and no memory write is issued. A status read clears this bit as well.
- R10: The memory port carries one request at a time. Address, direction and write data stay stable while mem_req_valid is high without mem_req_ready. Read data is taken in the handshake cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on the status address) |
| reg_addr | input | 4 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the read handshake cycle |
| per_req | input | 1 | Peripheral request for the next chunk |
| per_ack | output | 1 | One-cycle pulse marking the end of a served chunk |

## Verification
A status read and the completion of the final block can fall in the same cycle. Whether the flag survives depends on whether setting takes priority over clearing. The bench provokes this case by holding the read strobe on the status address every cycle while a stalled, paced chain runs to its end. It then counts the reads that return bit 0 set: the count must be exactly one. A count of zero means the completion was lost to the clear, and a count of two or more means the clear failed.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

    localparam int WORD_W     = 32;
    localparam int CNT_W      = 16;
    localparam int CHUNK_W    = 2;
    localparam int BURST_W    = 1 << CHUNK_W;
    localparam int DESC_WORDS = 5;
    localparam int FIDX_W     = $clog2(DESC_WORDS);
    localparam int REG_AW     = 4;

    typedef enum logic [1:0] {
        SEL_RUN  = 2'd0,
        SEL_PTR  = 2'd1,
        SEL_MODE = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [WORD_W-CNT_W-CHUNK_W-1:0] spare;
        logic [CHUNK_W-1:0]              chunk;
        logic [CNT_W-1:0]                beats;
    } cnt_word_t;

    typedef struct packed {
        logic [WORD_W-7:0] spare_hi;
        logic              dst_hold;
        logic              src_hold;
        logic              spare_lo;
        logic              paced;
        logic              dst_step;
        logic              src_step;
    } mode_word_t;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_FETCH,
        CH_CHECK,
        CH_WAIT,
        CH_READ,
        CH_WRITE,
        CH_LINK
    } ch_state_e;

    function automatic logic [WORD_W-1:0] next_addr(input logic [WORD_W-1:0] a,
                                                     input logic step);
        return step ? a + WORD_W'(4) : a;
    endfunction

    function automatic logic [BURST_W-1:0] chunk_len(input logic [CHUNK_W-1:0] c);
        return BURST_W'(1) << c;
    endfunction

endpackage

// File: rtl/lldma_regs.sv
module lldma_regs
    import lldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic [WORD_W-1:0] mode_q,
    input  logic              chain_done,
    input  logic              align_err,
    output logic              start,
    output logic [WORD_W-1:0] desc_ptr,
    output logic              mode_we,
    output logic              done_flag,
    output logic              err_flag
);

    reg_sel_e sel;
    logic     stat_rd;

    assign sel     = reg_sel_e'(reg_addr[3:2]);
    assign stat_rd = reg_rd && (sel == SEL_STAT);
    assign start   = reg_wr && (sel == SEL_RUN) && reg_wdata[0] && !busy;
    assign mode_we = reg_wr && (sel == SEL_MODE) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            desc_ptr  <= '0;
            done_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (reg_wr && sel == SEL_PTR && !busy) begin
                desc_ptr <= reg_wdata;
            end
            // a new event outranks the clear of the same cycle
            done_flag <= chain_done | (done_flag & ~stat_rd);
            err_flag  <= align_err  | (err_flag  & ~stat_rd);
        end
    end

    always_comb begin
        unique case (sel)
            SEL_RUN:  reg_rdata = {{(WORD_W-1){1'b0}}, busy};
            SEL_PTR:  reg_rdata = desc_ptr;
            SEL_MODE: reg_rdata = mode_q;
            default:  reg_rdata = {{(WORD_W-2){1'b0}}, err_flag, done_flag};
        endcase
    end

endmodule

// File: rtl/lldma_engine.sv
module lldma_engine
    import lldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] desc_ptr,
    input  logic              mode_we,
    input  logic [WORD_W-1:0] mode_wdata,
    output logic [WORD_W-1:0] mode_q,
    output logic              busy,
    output logic              chain_done,
    output logic              align_err,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [WORD_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              per_req,
    output logic              per_ack
);

    localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(DESC_WORDS - 1);

    ch_state_e           state;
    logic [FIDX_W-1:0]   fidx;
    logic [WORD_W-1:0]   cur_desc;
    logic [WORD_W-1:0]   src_a;
    logic [WORD_W-1:0]   dst_a;
    logic [WORD_W-1:0]   link;
    logic [WORD_W-1:0]   hold_data;
    cnt_word_t           cnt_w;
    mode_word_t          mode_w;
    logic [CNT_W-1:0]    left;
    logic [BURST_W-1:0]  in_chunk;
    logic                hs;
    logic                last_beat;
    logic                chunk_end;
    logic                misaligned;

    assign hs         = mem_req_valid && mem_req_ready;
    assign last_beat  = (left == CNT_W'(1));
    assign chunk_end  = mode_w.paced && (in_chunk == BURST_W'(1) || last_beat);
    assign misaligned = (dst_a[1:0] != 2'b00);

    assign mode_q     = mode_w;
    assign busy       = (state != CH_IDLE);
    assign chain_done = (state == CH_LINK) && (link == '0);
    assign align_err  = (state == CH_CHECK) && misaligned;
    assign per_ack    = (state == CH_WRITE) && hs && chunk_end;

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = hold_data;
        unique case (state)
            CH_FETCH: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = cur_desc + WORD_W'({fidx, 2'b00});
            end
            CH_READ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = src_a;
            end
            CH_WRITE: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = dst_a;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CH_IDLE;
            fidx      <= '0;
            cur_desc  <= '0;
            src_a     <= '0;
            dst_a     <= '0;
            link      <= '0;
            hold_data <= '0;
            cnt_w     <= '0;
            mode_w    <= '0;
            left      <= '0;
            in_chunk  <= '0;
        end else begin
            unique case (state)
                CH_IDLE: begin
                    if (mode_we) begin
                        mode_w <= mode_word_t'(mode_wdata);
                    end
                    if (start) begin
                        cur_desc <= desc_ptr;
                        fidx     <= '0;
                        state    <= CH_FETCH;
                    end
                end
                CH_FETCH: begin
                    if (hs) begin
                        unique case (fidx)
                            FIDX_W'(0): if (!mode_w.src_hold) src_a <= mem_rdata;
                            FIDX_W'(1): if (!mode_w.dst_hold) dst_a <= mem_rdata;
                            FIDX_W'(2): cnt_w  <= cnt_word_t'(mem_rdata);
                            FIDX_W'(3): mode_w <= mode_word_t'(mem_rdata);
                            default:    link   <= mem_rdata;
                        endcase
                        fidx <= fidx + FIDX_W'(1);
                        if (fidx == FIDX_LAST) begin
                            state <= CH_CHECK;
                        end
                    end
                end
                CH_CHECK: begin
                    left <= cnt_w.beats;
                    if (misaligned) begin
                        state <= CH_IDLE;
                    end else if (cnt_w.beats == '0) begin
                        state <= CH_LINK;
                    end else if (mode_w.paced) begin
                        state <= CH_WAIT;
                    end else begin
                        state <= CH_READ;
                    end
                end
                CH_WAIT: begin
                    if (per_req) begin
                        in_chunk <= chunk_len(cnt_w.chunk);
                        state    <= CH_READ;
                    end
                end
                CH_READ: begin
                    if (hs) begin
                        hold_data <= mem_rdata;
                        state     <= CH_WRITE;
                    end
                end
                CH_WRITE: begin
                    if (hs) begin
                        src_a    <= next_addr(src_a, mode_w.src_step);
                        dst_a    <= next_addr(dst_a, mode_w.dst_step);
                        left     <= left - CNT_W'(1);
                        in_chunk <= in_chunk - BURST_W'(1);
                        if (last_beat) begin
                            state <= CH_LINK;
                        end else if (chunk_end) begin
                            state <= CH_WAIT;
                        end else begin
                            state <= CH_READ;
                        end
                    end
                end
                default: begin
                    if (link == '0) begin
                        state <= CH_IDLE;
                    end else begin
                        cur_desc <= link;
                        fidx     <= '0;
                        state    <= CH_FETCH;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
    import lldma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [WORD_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              per_req,
    output logic              per_ack
);

    logic              start;
    logic [WORD_W-1:0] desc_ptr;
    logic              mode_we;
    logic [WORD_W-1:0] mode_q;
    logic              busy;
    logic              chain_done;
    logic              align_err;
    logic              done_flag;
    logic              err_flag;

    lldma_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .mode_q     (mode_q),
        .chain_done (chain_done),
        .align_err  (align_err),
        .start      (start),
        .desc_ptr   (desc_ptr),
        .mode_we    (mode_we),
        .done_flag  (done_flag),
        .err_flag   (err_flag)
    );

    lldma_engine u_engine (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .desc_ptr      (desc_ptr),
        .mode_we       (mode_we),
        .mode_wdata    (reg_wdata),
        .mode_q        (mode_q),
        .busy          (busy),
        .chain_done    (chain_done),
        .align_err     (align_err),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rdata     (mem_rdata),
        .per_req       (per_req),
        .per_ack       (per_ack)
    );

endmodule

// File: rtl/lldma_checker.sv
module lldma_checker
    import lldma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input logic              busy,
    input logic              chain_done,
    input logic              align_err,
    input logic              done_flag,
    input logic              err_flag,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [WORD_W-1:0] mem_req_addr,
    input logic [WORD_W-1:0] mem_req_wdata,
    input logic              per_ack
);

    logic stat_rd;
    assign stat_rd = reg_rd && (reg_addr[3:2] == 2'd3);

    assert_req_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

    assert_write_aligned_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (mem_req_addr[1:0] == 2'b00));

    assert_error_raises_flag_R9: assert property (@(posedge clk) disable iff (rst)
        align_err |=> err_flag);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req_valid && !per_ack));

    assert_stops_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        (chain_done || align_err) |=> !busy);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        chain_done |=> done_flag);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !chain_done) |=> !done_flag);

    assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        per_ack |=> !per_ack);

    assert_ack_on_write_R5: assert property (@(posedge clk) disable iff (rst)
        per_ack |-> (mem_req_valid && mem_req_write && mem_req_ready));

endmodule

bind lldma_channel lldma_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .busy          (busy),
    .chain_done    (chain_done),
    .align_err     (align_err),
    .done_flag     (done_flag),
    .err_flag      (err_flag),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .per_ack       (per_ack)
);

// File: tb/lldma_channel_bench.sv
module lldma_channel_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          MEM_WORDS  = 512;
    localparam int          LOG_DEPTH  = 1024;
    localparam logic [31:0] FIFO_ADDR  = 32'h0000_1000;
    localparam logic [3:0]  A_RUN  = 4'h0;
    localparam logic [3:0]  A_PTR  = 4'h4;
    localparam logic [3:0]  A_MODE = 4'h8;
    localparam logic [3:0]  A_STAT = 4'hC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic [31:0] mem_rdata;
    logic        per_req = 1'b1;
    logic        per_ack;

    logic [31:0] mem [0:MEM_WORDS-1];
    logic [31:0] fifo_ctr = 32'h5000_0000;
    logic [31:0] tx_addr [0:LOG_DEPTH-1];
    logic [31:0] tx_dat  [0:LOG_DEPTH-1];
    logic        tx_we   [0:LOG_DEPTH-1];
    int          tx_n  = 0;
    int          ack_n = 0;
    logic        stall_en = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic        bk_we = 1'b0;
    logic [31:0] bk_addr = '0;
    logic [31:0] bk_data = '0;

    logic [31:0] exp_a [0:63];
    logic        exp_w [0:63];
    int          exp_n = 0;

    int n_chk = 0;
    int n_err = 0;

    lldma_channel u_lldma_channel (
        .clk           (clk),
        .rst           (rst),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rdata     (mem_rdata),
        .per_req       (per_req),
        .per_ack       (per_ack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = (mem_req_addr == FIFO_ADDR) ? fifo_ctr : mem[mem_req_addr[10:2]];

    always @(posedge clk) begin
        if (bk_we) mem[bk_addr[10:2]] <= bk_data;
        if (!rst && mem_req_valid && mem_req_ready) begin
            if (tx_n < LOG_DEPTH) begin
                tx_addr[tx_n] <= mem_req_addr;
                tx_we[tx_n]   <= mem_req_write;
                tx_dat[tx_n]  <= mem_req_write ? mem_req_wdata : mem_rdata;
            end
            tx_n <= tx_n + 1;
            if (mem_req_write) begin
                if (mem_req_addr != FIFO_ADDR) mem[mem_req_addr[10:2]] <= mem_req_wdata;
            end else if (mem_req_addr == FIFO_ADDR) begin
                fifo_ctr <= fifo_ctr + 32'd1;
            end
        end
        if (!rst && per_ack) ack_n <= ack_n + 1;
    end

    always @(negedge clk) begin
        lfsr          <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_req_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bk_we = 1'b1; bk_addr = a; bk_data = d;
        @(negedge clk);
        bk_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] cw, input logic [31:0] mw, input logic [31:0] nx);
        poke(base,       s);
        poke(base + 4,   d);
        poke(base + 8,   cw);
        poke(base + 12,  mw);
        poke(base + 16,  nx);
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] d;
        int          k;
        d = 32'd1;
        for (k = 0; k < 3000 && d[0]; k++) reg_read(A_RUN, d);
        chk(req, d, 32'd0);
    endtask

    task automatic push(input logic [31:0] a, input logic w);
        exp_a[exp_n] = a; exp_w[exp_n] = w; exp_n++;
    endtask

    function automatic logic [31:0] cnt_word(input int ch, input int n);
        return {14'd0, 2'(ch), 16'(n)};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int t0, a0, n, exp_acks, bad_f, bad_d, seen;
        logic [31:0] f0;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // reset state
        reg_read(A_RUN, d);  chk("R1 run bit after reset", d, 0);
        reg_read(A_STAT, d); chk("R1 status after reset", d, 0);
        reg_read(A_PTR, d);  chk("R1 pointer after reset", d, 0);
        chk("R10 no request after reset", {31'd0, mem_req_valid}, 0);

        // sweep of byte length and chunk code, paced FIFO to memory
        for (int len = 1; len <= 12; len++) begin
            for (int ch = 0; ch <= 2; ch++) begin
                n = (len + 3) / 4;
                exp_acks = (n + (1 << ch) - 1) >> ch;
                stall_en = ((len + ch) % 2) == 1;
                put_desc(32'h100, FIFO_ADDR, 32'h200, cnt_word(ch, n), 32'h6, 32'h0);
                reg_write(A_MODE, 32'h0);
                reg_write(A_PTR, 32'h100);
                t0 = tx_n; a0 = ack_n; f0 = fifo_ctr;
                reg_write(A_RUN, 32'h1);
                reg_read(A_RUN, d); chk("R1 run bit while active", d, 1);
                wait_idle("R1 run bit clears at chain end");
                bad_f = 0; bad_d = 0;
                for (int k = 0; k < 5; k++)
                    if (tx_we[t0+k] || tx_addr[t0+k] != 32'h100 + 4*k) bad_f++;
                for (int i = 0; i < n; i++) begin
                    if (tx_we[t0+5+2*i] || tx_addr[t0+5+2*i] != FIFO_ADDR) bad_d++;
                    if (!tx_we[t0+6+2*i] || tx_addr[t0+6+2*i] != 32'h200 + 4*i
                        || tx_dat[t0+6+2*i] != f0 + i) bad_d++;
                end
                chk("R2 five fetch reads in order before data", bad_f, 0);
                chk("R3 transactions for ceil(len/4) beats", tx_n - t0, 5 + 2*n);
                chk("R4 fixed source, stepping destination, data order", bad_d, 0);
                chk("R5 one ack per chunk", ack_n - a0, exp_acks);
                reg_read(A_STAT, d); chk("R8 completion flag", d, 1);
                reg_read(A_STAT, d); chk("R8 flag cleared by read", d, 0);
            end
        end
        stall_en = 1'b0;

        // unpaced copy with stepping source and fixed destination, no request
        poke(32'h040, 32'hCAFE_0001);
        poke(32'h044, 32'hCAFE_0002);
        poke(32'h048, 32'hCAFE_0003);
        put_desc(32'h100, 32'h040, 32'h380, cnt_word(0, 3), 32'h1, 32'h0);
        per_req = 1'b0;
        reg_write(A_MODE, 32'h0);
        t0 = tx_n; a0 = ack_n;
        reg_write(A_RUN, 32'h1);
        wait_idle("R5 unpaced run ends without request");
        bad_d = 0;
        for (int i = 0; i < 3; i++) begin
            if (tx_addr[t0+5+2*i] != 32'h040 + 4*i) bad_d++;
            if (tx_addr[t0+6+2*i] != 32'h380 || tx_dat[t0+6+2*i] != 32'hCAFE_0001 + i) bad_d++;
        end
        chk("R4 independent step modes", bad_d, 0);
        chk("R4 fixed destination holds last word", mem[9'h0E0], 32'hCAFE_0003);
        chk("R5 no ack when unpaced", ack_n - a0, 0);
        reg_read(A_STAT, d);

        // pacing: no data until per_req, one chunk per request
        put_desc(32'h100, FIFO_ADDR, 32'h200, cnt_word(1, 4), 32'h6, 32'h0);
        t0 = tx_n; a0 = ack_n;
        reg_write(A_RUN, 32'h1);
        repeat (30) @(negedge clk);
        chk("R5 only fetch before request", tx_n - t0, 5);
        reg_read(A_RUN, d); chk("R1 still active while waiting", d, 1);
        per_req = 1'b1;
        @(negedge clk);
        per_req = 1'b0;
        repeat (30) @(negedge clk);
        chk("R5 one request moves one chunk", tx_n - t0, 9);
        chk("R5 ack after first chunk", ack_n - a0, 1);
        per_req = 1'b1;
        wait_idle("R1 paced run ends");
        chk("R5 second chunk completes block", tx_n - t0, 13);
        reg_read(A_STAT, d);

        // chain of three with destination hold; ignored words are misaligned
        poke(32'h040, 32'hBEEF_0040);
        put_desc(32'h100, FIFO_ADDR, 32'h300, cnt_word(0, 2), 32'h26, 32'h140);
        put_desc(32'h140, FIFO_ADDR, 32'h003, cnt_word(0, 3), 32'h26, 32'h180);
        put_desc(32'h180, 32'h040,   32'hFFF, cnt_word(0, 1), 32'h3,  32'h0);
        exp_n = 0;
        for (int k = 0; k < 5; k++) push(32'h100 + 4*k, 1'b0);
        for (int i = 0; i < 2; i++) begin push(FIFO_ADDR, 1'b0); push(32'h300 + 4*i, 1'b1); end
        for (int k = 0; k < 5; k++) push(32'h140 + 4*k, 1'b0);
        for (int i = 0; i < 3; i++) begin push(FIFO_ADDR, 1'b0); push(32'h308 + 4*i, 1'b1); end
        for (int k = 0; k < 5; k++) push(32'h180 + 4*k, 1'b0);
        push(32'h040, 1'b0); push(32'h314, 1'b1);
        reg_write(A_MODE, 32'h0);
        reg_write(A_PTR, 32'h100);
        t0 = tx_n;
        reg_write(A_RUN, 32'h1);
        wait_idle("R7 chain ends at null link");
        chk("R7 transactions over three descriptors", tx_n - t0, exp_n);
        bad_d = 0;
        for (int k = 0; k < exp_n; k++)
            if (tx_addr[t0+k] != exp_a[k] || tx_we[t0+k] != exp_w[k]) bad_d++;
        chk("R6 held destination continues across links", bad_d, 0);
        chk("R6 last block data", mem[9'h0C5], 32'hBEEF_0040);
        reg_read(A_MODE, d); chk("R6 mode word replaced by fetch", d, 32'h3);
        reg_read(A_STAT, d); chk("R8 chain completion only", d, 1);

        // software mode word governs the first fetch
        reg_write(A_MODE, 32'h20);
        reg_read(A_MODE, d); chk("R6 mode word readback", d, 32'h20);
        put_desc(32'h1C0, FIFO_ADDR, 32'h003, cnt_word(0, 1), 32'h6, 32'h0);
        reg_write(A_PTR, 32'h1C0);
        t0 = tx_n;
        reg_write(A_RUN, 32'h1);
        wait_idle("R1 single block ends");
        chk("R6 first fetch honours software hold", tx_addr[t0+6], 32'h318);
        reg_read(A_STAT, d); chk("R9 no error when word ignored", d, 1);

        // misaligned destination
        reg_write(A_MODE, 32'h0);
        put_desc(32'h100, FIFO_ADDR, 32'h202, cnt_word(0, 2), 32'h6, 32'h0);
        reg_write(A_PTR, 32'h100);
        t0 = tx_n;
        reg_write(A_RUN, 32'h1);
        wait_idle("R9 run bit clears on error");
        chk("R9 only fetch reads, no write", tx_n - t0, 5);
        reg_read(A_STAT, d); chk("R9 error flag", d, 2);
        reg_read(A_STAT, d); chk("R9 error flag cleared by read", d, 0);

        // completion colliding with a status read held every cycle
        put_desc(32'h100, FIFO_ADDR, 32'h200, cnt_word(0, 5), 32'h6, 32'h0);
        stall_en = 1'b1;
        reg_write(A_RUN, 32'h1);
        seen = 0;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = A_STAT;
        for (int c = 0; c < 300; c++) begin
            #1 if (reg_rdata[0]) seen++;
            @(negedge clk);
        end
        reg_rd = 1'b0;
        stall_en = 1'b0;
        chk("R8 completion reported exactly once under constant reads", seen, 1);
        reg_read(A_RUN, d); chk("R1 chain finished during reads", d, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule